// File: doc/BRIEF.md
# Configuration Space Access Port Decoder

This block sits on a host I/O port bus and turns two port locations into configuration-space accesses. A 32-bit selector register at port 0xCF8 names a bus, a device/function and a dword-aligned register. A four-byte data window at ports 0xCFC to 0xCFF carries byte, word or dword reads and writes through to the configuration space of the selected function. The targets' own configuration storage lies outside the block. The block presents each qualified access on a configuration request interface. It takes back a presence flag and the read data from the target.

An I/O access is one strobed cycle, with address, size, direction and write data. A forwarded access appears on `cfg_req` one cycle after the strobe. Every claimed read returns its data on `io_rdata` with `io_rvalid` two cycles after the strobe. Data-window cycles are qualified on the selector's enable bit, on its low two bits being zero, and on the target being present. A read that fails any of these returns all ones in the requested byte lanes.

Top module: `cfg_port_decoder`

## Requirements
- R1: The selector register is written only by a write strobe at port 0xCF8 with size dword (io_size encoding 0 = byte, 1 = word, 2 = dword, 3 = reserved). Writes of any other size, or to ports 0xCF9 to 0xCFB, leave it unchanged.
- R2: A dword read at port 0xCF8 returns the selector exactly as last written, with io_rvalid high two cycles after the strobe.
- R3: A qualified data-window access at port 0xCFC+k (k = 0..3) of size byte, word or dword raises cfg_req for one cycle, one cycle after the strobe. cfg_len equals io_size, and cfg_off equals selector bits 7:2 followed by k in bits 1:0.
- R4: cfg_bus always shows selector bits 23:16, and cfg_devfn always shows selector bits 15:8.
- R5: With selector bit 31 clear, data-window cycles raise no cfg_req. Reads then return all ones in the requested lanes.
- R6: With selector bits 1:0 not both zero, data-window cycles raise no cfg_req. Reads then return all ones in the requested lanes.
- R7: With cfg_present low during the strobe, no cfg_req is raised. A read then returns all ones in the requested lanes.
- R8: A forwarded read returns cfg_rdata (right-aligned) shifted left by 8*k bits. It is masked to the requested lanes: lanes from k up to k+bytes-1, with lanes above 3 dropped. Unrequested lanes read zero. io_rvalid is high two cycles after the strobe.
- R9: On a forwarded write, cfg_we is high and cfg_wdata equals io_wdata shifted right by 8*k bits.
- R10: After reset the selector is zero, and cfg_req and io_rvalid are low.
- R11: Strobes at unclaimed ports, and data-window strobes with the reserved size, raise neither cfg_req nor io_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O access strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Write data, lane-positioned by port address |
| io_rdata | output | 32 | Read data, lane-positioned |
| io_rvalid | output | 1 | Read data valid |
| cfg_req | output | 1 | Configuration access pulse |
| cfg_we | output | 1 | Configuration access is a write |
| cfg_bus | output | 8 | Selected bus number |
| cfg_devfn | output | 8 | Selected device/function |
| cfg_off | output | 8 | Configuration byte offset |
| cfg_len | output | 2 | Access size, same encoding as io_size |
| cfg_wdata | output | 32 | Right-aligned write data |
| cfg_present | input | 1 | Selected function exists |
| cfg_rdata | input | 32 | Right-aligned read data from target |

## Verification
A corrupted selector register is visible at once: cfg_bus and cfg_devfn mirror it in the cycle after the write, and a dword read at 0xCF8 shows every bit two cycles later. A wrong qualification state shows one cycle after a data-window strobe, as a cfg_req that appears or goes missing. A wrong lane position or mask shows two cycles after a read strobe in io_rdata. The directed cases cover each port lane and each size, and each of the three reasons an access is discarded.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } io_size_e;

  typedef enum logic [1:0] {
    RK_NONE   = 2'd0,
    RK_SEL    = 2'd1,
    RK_TARGET = 2'd2,
    RK_FILL   = 2'd3
  } rd_kind_e;

  // byte-lane enables for a size starting at a lane, lanes past the top dropped
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lane);
    logic [3:0] base;
    case (size)
      SZ_BYTE: base = 4'b0001;
      SZ_WORD: base = 4'b0011;
      default: base = 4'b1111;
    endcase
    return base << lane;
  endfunction
endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (wr_en) q <= wdata;
  end
endmodule

// File: rtl/cfg_window_decode.sv
module cfg_window_decode
  import cfgdec_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          LW        = 2,
  parameter logic [15:0] SEL_PORT  = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC
) (
  input  logic          io_req,
  input  logic          io_we,
  input  logic [AW-1:0] io_addr,
  input  logic [1:0]    io_size,
  input  logic          sel_en,
  input  logic [1:0]    sel_low,
  input  logic          present,
  output logic          sel_wr,
  output logic          fwd,
  output rd_kind_e      kind
);
  logic sel_hit, win_hit, size_ok, qual;

  always_comb begin
    sel_hit = (io_addr == SEL_PORT[AW-1:0]) && (io_size == SZ_DWORD);
    win_hit = (io_addr[AW-1:LW] == DATA_PORT[AW-1:LW]);
    size_ok = (io_size != SZ_RSVD);
    qual    = sel_en && (sel_low == 2'b00) && present;
    sel_wr  = io_req && io_we && sel_hit;
    fwd     = io_req && win_hit && size_ok && qual;
    if (io_req && !io_we && sel_hit)
      kind = RK_SEL;
    else if (io_req && !io_we && win_hit && size_ok)
      kind = qual ? RK_TARGET : RK_FILL;
    else
      kind = RK_NONE;
  end
endmodule

// File: rtl/cfg_read_return.sv
module cfg_read_return
  import cfgdec_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  rd_kind_e      kind,
  input  logic [LW-1:0] lane,
  input  logic [1:0]    size,
  input  logic [DW-1:0] tgt_data,
  input  logic [DW-1:0] sel_val,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int NB = DW / 8;
  logic [3:0]    bmask;
  logic [DW-1:0] wmask;
  logic [DW-1:0] shifted;

  always_comb bmask = lane_mask(size, lane);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign wmask[8*b +: 8] = {8{bmask[b]}};
  end

  always_comb shifted = tgt_data << (8 * lane);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= (kind != RK_NONE);
      case (kind)
        RK_SEL:    rdata <= sel_val;
        RK_TARGET: rdata <= shifted & wmask;
        RK_FILL:   rdata <= wmask;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgdec_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter logic [15:0] SEL_PORT  = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_req,
  input  logic          io_we,
  input  logic [AW-1:0] io_addr,
  input  logic [1:0]    io_size,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_rvalid,
  output logic          cfg_req,
  output logic          cfg_we,
  output logic [7:0]    cfg_bus,
  output logic [7:0]    cfg_devfn,
  output logic [7:0]    cfg_off,
  output logic [1:0]    cfg_len,
  output logic [DW-1:0] cfg_wdata,
  input  logic          cfg_present,
  input  logic [DW-1:0] cfg_rdata
);
  localparam int LW = $clog2(DW / 8);

  logic [DW-1:0] sel_q;
  logic          sel_wr, fwd;
  rd_kind_e      kind_d, kind_q;
  logic [LW-1:0] lane_q;
  logic [1:0]    size_q;

  cfg_sel_reg #(.DW(DW)) u_sel (
    .clk(clk), .rst(rst), .wr_en(sel_wr), .wdata(io_wdata), .q(sel_q)
  );

  cfg_window_decode #(
    .AW(AW), .LW(LW), .SEL_PORT(SEL_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_size(io_size),
    .sel_en(sel_q[DW-1]), .sel_low(sel_q[1:0]), .present(cfg_present),
    .sel_wr(sel_wr), .fwd(fwd), .kind(kind_d)
  );

  always_comb begin
    cfg_bus   = sel_q[23:16];
    cfg_devfn = sel_q[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_off   <= '0;
      cfg_len   <= '0;
      cfg_wdata <= '0;
      kind_q    <= RK_NONE;
      lane_q    <= '0;
      size_q    <= '0;
    end else begin
      cfg_req <= fwd;
      kind_q  <= kind_d;
      lane_q  <= io_addr[LW-1:0];
      size_q  <= io_size;
      if (fwd) begin
        cfg_we    <= io_we;
        cfg_off   <= {sel_q[7:2], io_addr[1:0]};
        cfg_len   <= io_size;
        cfg_wdata <= io_wdata >> (8 * io_addr[LW-1:0]);
      end
    end
  end

  cfg_read_return #(.DW(DW), .LW(LW)) u_ret (
    .clk(clk), .rst(rst), .kind(kind_q), .lane(lane_q), .size(size_q),
    .tgt_data(cfg_rdata), .sel_val(sel_q), .rdata(io_rdata), .rvalid(io_rvalid)
  );
endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        io_req,
  input logic        io_we,
  input logic [15:0] io_addr,
  input logic [1:0]  io_size,
  input logic        io_rvalid,
  input logic        cfg_req,
  input logic        cfg_present,
  input logic [7:0]  cfg_off,
  input logic [31:0] sel
);
  p_req_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> $past(io_req));
  p_req_offset_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> (cfg_off[7:2] == sel[7:2]));
  p_req_enabled_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> $past(sel[31]));
  p_req_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> ($past(sel[1:0]) == 2'b00));
  p_req_present_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> $past(cfg_present));
  p_rvalid_read_r8: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> ($past(io_req, 2) && !$past(io_we, 2)));
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (rst)
    $past(io_req && io_we && (io_addr == 16'hCF8) && (io_size != 2'd2)) |-> $stable(sel));
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cfg_req && !io_rvalid && (sel == 32'h0)));
endmodule

bind cfg_port_decoder cfg_port_decoder_chk u_chk (
  .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
  .io_size(io_size), .io_rvalid(io_rvalid), .cfg_req(cfg_req),
  .cfg_present(cfg_present), .cfg_off(cfg_off), .sel(sel_q)
);

// File: tb/sim_cfg_port_decoder.sv
module sim_cfg_port_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_rvalid;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_bus, cfg_devfn, cfg_off;
  logic [1:0]  cfg_len;
  logic [31:0] cfg_wdata;
  logic        cfg_present = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int total = 0, bad = 0, cycles = 0;
  logic        o_req, o_we, o_rv;
  logic [7:0]  o_off, o_bus, o_devfn;
  logic [1:0]  o_len;
  logic [31:0] o_wd, o_rd;

  always #10 clk = ~clk;

  cfg_port_decoder u0 (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
    .cfg_off(cfg_off), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata),
    .cfg_present(cfg_present), .cfg_rdata(cfg_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=5000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mask(input logic [1:0] sz, input logic [1:0] lane);
    logic [3:0] b;
    logic [31:0] m;
    b = ((sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111) << lane;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{b[i]}};
    return m;
  endfunction

  task automatic do_io(input logic we, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic p, input logic [31:0] trd);
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
    cfg_present = p; cfg_rdata = trd;
    @(negedge clk);
    io_req = 1'b0;
    o_req = cfg_req; o_we = cfg_we; o_off = cfg_off; o_len = cfg_len; o_wd = cfg_wdata;
    o_bus = cfg_bus; o_devfn = cfg_devfn;
    @(negedge clk);
    o_rv = io_rvalid; o_rd = io_rdata;
  endtask

  task automatic t_reset;
    check("R10 cfg_req", {31'd0, cfg_req}, 0);
    check("R10 io_rvalid", {31'd0, io_rvalid}, 0);
    do_io(0, 16'hCF8, 2, 0, 0, 0);
    check("R10 selector zero", o_rd, 32'h0);
  endtask

  task automatic t_sel_rw;
    do_io(1, 16'hCF8, 2, 32'h8012_3404, 0, 0);
    check("R4 bus", {24'd0, o_bus}, 32'h12);
    check("R4 devfn", {24'd0, o_devfn}, 32'h34);
    check("R1 write no cfg_req", {31'd0, o_req}, 0);
    do_io(0, 16'hCF8, 2, 0, 0, 0);
    check("R2 rvalid", {31'd0, o_rv}, 1);
    check("R2 readback", o_rd, 32'h8012_3404);
  endtask

  task automatic t_sel_ignored;
    do_io(1, 16'hCF8, 0, 32'hFFFF_FFFF, 0, 0);
    do_io(1, 16'hCF8, 1, 32'hFFFF_FFFF, 0, 0);
    do_io(1, 16'hCF9, 2, 32'hFFFF_FFFF, 0, 0);
    do_io(0, 16'hCF8, 2, 0, 0, 0);
    check("R1 narrow/offset writes ignored", o_rd, 32'h8012_3404);
  endtask

  task automatic t_dword_read;
    do_io(0, 16'hCFC, 2, 0, 1, 32'hDEAD_BEEF);
    check("R3 cfg_req", {31'd0, o_req}, 1);
    check("R3 off", {24'd0, o_off}, 32'h04);
    check("R3 len", {30'd0, o_len}, 2);
    check("R8 rvalid", {31'd0, o_rv}, 1);
    check("R8 dword data", o_rd, 32'hDEAD_BEEF);
  endtask

  task automatic t_byte_lanes;
    for (int k = 0; k < 4; k++) begin
      do_io(0, 16'hCFC + 16'(k), 0, 0, 1, 32'h0000_00A5 + 32'(k));
      check("R3 byte off", {24'd0, o_off}, 32'h04 + 32'(k));
      check("R8 byte lane", o_rd, (32'h0000_00A5 + 32'(k)) << (8 * k));
    end
    do_io(0, 16'hCFE, 1, 0, 1, 32'hFFFF_1234);
    check("R8 word lanes 2-3", o_rd, 32'h1234_0000);
    do_io(0, 16'hCFF, 1, 0, 1, 32'h0000_5678);
    check("R8 word at top lane truncated", o_rd, 32'h7800_0000);
  endtask

  task automatic t_write;
    do_io(1, 16'hCFD, 0, 32'h0000_9900, 1, 0);
    check("R9 cfg_we", {31'd0, o_we}, 1);
    check("R9 wdata shifted", o_wd, 32'h0000_0099);
    check("R3 write off", {24'd0, o_off}, 32'h05);
    check("R9 no rvalid on write", {31'd0, o_rv}, 0);
  endtask

  task automatic t_discard(input string tag, input logic [31:0] selv, input logic p);
    do_io(1, 16'hCF8, 2, selv, 0, 0);
    do_io(0, 16'hCFD, 1, 0, p, 32'h1111_2222);
    check({tag, " read no cfg_req"}, {31'd0, o_req}, 0);
    check({tag, " read fill ones"}, o_rd, exp_mask(2'd1, 2'd1));
    do_io(1, 16'hCFC, 2, 32'h1234_5678, p, 0);
    check({tag, " write no cfg_req"}, {31'd0, o_req}, 0);
  endtask

  task automatic t_unclaimed;
    do_io(1, 16'hCF8, 2, 32'h8000_0000, 0, 0);
    do_io(0, 16'h0080, 2, 0, 1, 32'h5555_5555);
    check("R11 other port no req", {31'd0, o_req}, 0);
    check("R11 other port no rvalid", {31'd0, o_rv}, 0);
    do_io(0, 16'hCFC, 3, 0, 1, 32'h5555_5555);
    check("R11 reserved size no req", {31'd0, o_req}, 0);
    check("R11 reserved size no rvalid", {31'd0, o_rv}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sel_rw();
    t_sel_ignored();
    t_dword_read();
    t_byte_lanes();
    t_write();
    t_discard("R5", 32'h0012_3404, 1'b1);
    t_discard("R6", 32'h8012_3405, 1'b1);
    t_discard("R7", 32'h8012_3404, 1'b0);
    t_unclaimed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule